// File: doc/BRIEF.md
# Interlaced Sensor Readout Timing Generator

This block produces the row and column timing of an image-sensor style readout. It walks a programmed window of rows, one row at a time, and drives a row index, a pixel-column strobe, a frame-valid flag and a line-valid flag. The downstream pixel path uses these signals to capture the image.

Three readout orders are available. Progressive walks every row of the window. Two-field interlaced reads the even rows first, inserts a gap of field-blanking rows, then reads the odd rows. Single-field reads only the rows whose parity matches the window's first row. Vertical blanking closes every frame. Its length comes from one of two selectable blanking contexts. In two-field mode the field gap is subtracted from it, and the total is held to a minimum.

Line-valid can be driven in three shapes: gated to image pixels, running continuously through the blanking rows, or the continuous shape XORed with frame-valid. All settings are captured at frame boundaries, so software may rewrite them at any time.

Top module: `rdt_readout_gen`

## Requirements
- R1: While `rst` is high, all outputs are 0 and the configuration inputs are captured. The first clock edge after reset is released presents the first cycle of a vertical blanking period.
- R2: A row lasts W + `cfg_hblank` cycles, where W is `cfg_width` with 0 treated as 1. `col_strobe` is high for the first W cycles of each image row and is low in every other cycle.
- R3: When `cfg_mode` is neither 1 nor 2, the rows S, S+1, … S+H−1 are output in order. S is `cfg_row_start` and H is `cfg_height`, with values below 2 treated as 2.
- R4: When `cfg_mode` = 1, the even-numbered rows of the window are output in ascending order. Then come the field blanking rows, then the odd-numbered rows in ascending order, then the trailing vertical blanking.
- R5: When `cfg_mode` = 2, H/2 rows (rounded down) are output: S, S+2, S+4, … The field output therefore has the parity of S.
- R6: Outside mode 1, vertical blanking lasts max(V, 4) rows. In mode 1, the trailing blanking lasts max(V − F, 4 − F, 1) rows, where F is `cfg_fblank` and negative terms count as 0.
- R7: V is `cfg_vblank_a` when `cfg_ctx_b` = 0 and `cfg_vblank_b` when `cfg_ctx_b` = 1.
- R8: `frame_valid` is high for every cycle of every image row, including its horizontal blanking. It is low for all blanking rows. `row_idx` shows the image row number while `frame_valid` is high and 0 otherwise.
- R9: `cfg_lv_fmt` selects the shape of `line_valid`. Values 0 and 3 give it equal to `col_strobe`. Value 1 gives it high during the first W cycles of every row, image or blanking. Value 2 gives the value-1 shape XORed with `frame_valid`.
- R10: Configuration is captured during reset and at the clock edge where the first image row of a frame begins. A change made at any other time affects only the frame that follows.
- R11: In mode 1 with `cfg_fblank` = 0, the odd field follows the even field with no rows between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_row_start | input | ROW_W | First row of the window |
| cfg_height | input | ROW_W | Window height in rows |
| cfg_width | input | COL_W | Active pixels per row |
| cfg_hblank | input | HB_W | Horizontal blanking cycles per row |
| cfg_fblank | input | FB_W | Field blanking rows (two-field mode) |
| cfg_vblank_a | input | VB_W | Vertical blanking setting, context A |
| cfg_vblank_b | input | VB_W | Vertical blanking setting, context B |
| cfg_ctx_b | input | 1 | Select context B for vertical blanking |
| cfg_mode | input | 3 | Readout order: 1 two-field, 2 single-field, other progressive |
| cfg_lv_fmt | input | 2 | Line-valid shape: 0/3 gated, 1 continuous, 2 XOR |
| row_idx | output | ROW_W | Current image row number |
| col_strobe | output | 1 | High on active pixel cycles of image rows |
| frame_valid | output | 1 | High during image rows |
| line_valid | output | 1 | Line-valid in the selected shape |

## Verification
The assertions assume that configuration is stable enough for the block's own capture to be meaningful. They compare outputs against the captured format and parity, never against the raw inputs, which may move at any time. They also assume the window stays within the row address range, so that row numbers do not wrap. The stimulus rewrites every setting only after a frame's first image cycle has appeared at the outputs. This places the next capture a whole frame later, and all windows it programs sit well inside the address range.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  typedef enum logic [1:0] {
    PH_VBLANK = 2'd0,
    PH_FIELD0 = 2'd1,
    PH_FBLANK = 2'd2,
    PH_FIELD1 = 2'd3
  } phase_t;

  localparam logic [2:0] MODE_TWO_FIELD = 3'd1;
  localparam logic [2:0] MODE_ONE_FIELD = 3'd2;

  localparam logic [1:0] LVF_CONT = 2'd1;
  localparam logic [1:0] LVF_XOR  = 2'd2;

  localparam int MIN_VBLANK = 4;

endpackage

// File: rtl/rdt_cfg_shadow.sv
module rdt_cfg_shadow #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int HB_W  = 10,
  parameter int FB_W  = 8,
  parameter int VB_W  = 9,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] in_row_start,
  input  logic [ROW_W-1:0] in_height,
  input  logic [COL_W-1:0] in_width,
  input  logic [HB_W-1:0]  in_hblank,
  input  logic [FB_W-1:0]  in_fblank,
  input  logic [VB_W-1:0]  in_vb_a,
  input  logic [VB_W-1:0]  in_vb_b,
  input  logic             in_ctx_b,
  input  logic [2:0]       in_mode,
  input  logic [1:0]       in_lv_fmt,
  output logic [LEN_W-1:0] row_len_m1,
  output logic [COL_W-1:0] act_w,
  output logic [ROW_W-1:0] f0_first,
  output logic [ROW_W-1:0] f0_cnt,
  output logic [ROW_W-1:0] f1_first,
  output logic [ROW_W-1:0] f1_cnt,
  output logic [FB_W-1:0]  fb_cnt,
  output logic [VB_W-1:0]  vb_cnt,
  output logic             two_field,
  output logic             one_field,
  output logic             step2,
  output logic             start_odd,
  output logic [1:0]       lv_fmt
);
  import rdt_pkg::*;

  localparam int EXT_W = ((VB_W > FB_W) ? VB_W : FB_W) + 1;

  logic [COL_W-1:0] w_eff;
  logic [ROW_W-1:0] h_eff, h_half;
  logic [ROW_W-1:0] f0_first_n, f0_n, f1_first_n, f1_n;
  logic             two_n, one_n;
  logic [EXT_W-1:0] vb_x, fb_x, t_diff, t_min, t_tr, t_pr;
  logic [VB_W-1:0]  vb_n;

  always_comb begin
    w_eff  = (in_width == '0) ? COL_W'(1) : in_width;
    h_eff  = (in_height < ROW_W'(2)) ? ROW_W'(2) : in_height;
    h_half = h_eff >> 1;
    two_n  = (in_mode == MODE_TWO_FIELD);
    one_n  = (in_mode == MODE_ONE_FIELD);

    if (two_n) begin
      // even field first: the first even row at or after the start
      f0_first_n = in_row_start + ROW_W'(in_row_start[0]);
      f0_n       = in_row_start[0] ? h_half : (h_eff - h_half);
      f1_first_n = in_row_start + ROW_W'(!in_row_start[0]);
      f1_n       = h_eff - f0_n;
    end else if (one_n) begin
      f0_first_n = in_row_start;
      f0_n       = h_half;
      f1_first_n = '0;
      f1_n       = ROW_W'(1);
    end else begin
      f0_first_n = in_row_start;
      f0_n       = h_eff;
      f1_first_n = '0;
      f1_n       = ROW_W'(1);
    end

    vb_x   = EXT_W'(in_ctx_b ? in_vb_b : in_vb_a);
    fb_x   = EXT_W'(in_fblank);
    t_diff = (vb_x > fb_x) ? (vb_x - fb_x) : '0;
    t_min  = (fb_x < EXT_W'(MIN_VBLANK)) ? (EXT_W'(MIN_VBLANK) - fb_x) : '0;
    t_tr   = (t_diff > t_min) ? t_diff : t_min;
    if (t_tr == '0) t_tr = EXT_W'(1);
    t_pr   = (vb_x < EXT_W'(MIN_VBLANK)) ? EXT_W'(MIN_VBLANK) : vb_x;
    vb_n   = VB_W'(two_n ? t_tr : t_pr);
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      row_len_m1 <= LEN_W'(w_eff) + LEN_W'(in_hblank) - LEN_W'(1);
      act_w      <= w_eff;
      f0_first   <= f0_first_n;
      f0_cnt     <= f0_n;
      f1_first   <= f1_first_n;
      f1_cnt     <= f1_n;
      fb_cnt     <= two_n ? in_fblank : '0;
      vb_cnt     <= vb_n;
      two_field  <= two_n;
      one_field  <= one_n;
      step2      <= two_n || one_n;
      start_odd  <= in_row_start[0];
      lv_fmt     <= in_lv_fmt;
    end
  end

endmodule

// File: rtl/rdt_col_timer.sv
module rdt_col_timer #(
  parameter int COL_W = 10,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] row_len_m1,
  input  logic [COL_W-1:0] act_w,
  output logic             col_active,
  output logic             row_last
);

  logic [LEN_W-1:0] col;

  assign row_last   = (col == row_len_m1);
  assign col_active = (col < LEN_W'(act_w));

  always_ff @(posedge clk) begin
    if (rst)           col <= '0;
    else if (row_last) col <= '0;
    else               col <= col + LEN_W'(1);
  end

endmodule

// File: rtl/rdt_row_seq.sv
module rdt_row_seq #(
  parameter int ROW_W = 10,
  parameter int FB_W  = 8,
  parameter int VB_W  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_last,
  input  logic [ROW_W-1:0] f0_first,
  input  logic [ROW_W-1:0] f0_cnt,
  input  logic [ROW_W-1:0] f1_first,
  input  logic [ROW_W-1:0] f1_cnt,
  input  logic [FB_W-1:0]  fb_cnt,
  input  logic [VB_W-1:0]  vb_cnt,
  input  logic             two_field,
  input  logic             step2,
  output logic             in_image,
  output logic [ROW_W-1:0] row_addr,
  output logic             frame_start
);
  import rdt_pkg::*;

  localparam int BL_W  = (VB_W > FB_W) ? VB_W : FB_W;
  localparam int CNT_W = ((ROW_W > BL_W) ? ROW_W : BL_W) + 1;

  phase_t           phase;
  logic [CNT_W-1:0] rcnt;
  logic [CNT_W-1:0] plen;
  logic             phase_last;
  logic [ROW_W-1:0] r_lo;

  always_comb begin
    case (phase)
      PH_VBLANK: plen = CNT_W'(vb_cnt);
      PH_FIELD0: plen = CNT_W'(f0_cnt);
      PH_FBLANK: plen = CNT_W'(fb_cnt);
      default:   plen = CNT_W'(f1_cnt);
    endcase
  end

  assign phase_last  = (rcnt == plen - CNT_W'(1));
  assign frame_start = row_last && phase_last && (phase == PH_VBLANK);
  assign in_image    = (phase == PH_FIELD0) || (phase == PH_FIELD1);
  assign r_lo        = rcnt[ROW_W-1:0];

  always_comb begin
    case (phase)
      PH_FIELD0: row_addr = f0_first + (step2 ? (r_lo << 1) : r_lo);
      PH_FIELD1: row_addr = f1_first + (r_lo << 1);
      default:   row_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_VBLANK;
      rcnt  <= '0;
    end else if (row_last) begin
      if (phase_last) begin
        rcnt <= '0;
        case (phase)
          PH_VBLANK: phase <= PH_FIELD0;
          PH_FIELD0: begin
            if (!two_field)          phase <= PH_VBLANK;
            else if (fb_cnt != '0)   phase <= PH_FBLANK;
            else                     phase <= PH_FIELD1;
          end
          PH_FBLANK: phase <= PH_FIELD1;
          default:   phase <= PH_VBLANK;
        endcase
      end else begin
        rcnt <= rcnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rdt_out_stage.sv
module rdt_out_stage #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_image,
  input  logic             col_active,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [1:0]       lv_fmt,
  output logic [ROW_W-1:0] row_idx,
  output logic             col_strobe,
  output logic             frame_valid,
  output logic             line_valid
);
  import rdt_pkg::*;

  logic lv_n;

  always_comb begin
    case (lv_fmt)
      LVF_CONT: lv_n = col_active;
      LVF_XOR:  lv_n = col_active ^ in_image;
      default:  lv_n = col_active & in_image;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx     <= '0;
      col_strobe  <= 1'b0;
      frame_valid <= 1'b0;
      line_valid  <= 1'b0;
    end else begin
      row_idx     <= row_addr;
      col_strobe  <= col_active & in_image;
      frame_valid <= in_image;
      line_valid  <= lv_n;
    end
  end

endmodule

// File: rtl/rdt_readout_gen.sv
module rdt_readout_gen #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int HB_W  = 10,
  parameter int FB_W  = 8,
  parameter int VB_W  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] cfg_row_start,
  input  logic [ROW_W-1:0] cfg_height,
  input  logic [COL_W-1:0] cfg_width,
  input  logic [HB_W-1:0]  cfg_hblank,
  input  logic [FB_W-1:0]  cfg_fblank,
  input  logic [VB_W-1:0]  cfg_vblank_a,
  input  logic [VB_W-1:0]  cfg_vblank_b,
  input  logic             cfg_ctx_b,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_lv_fmt,
  output logic [ROW_W-1:0] row_idx,
  output logic             col_strobe,
  output logic             frame_valid,
  output logic             line_valid
);

  localparam int LEN_W = ((COL_W > HB_W) ? COL_W : HB_W) + 1;

  logic [LEN_W-1:0] sh_row_len_m1;
  logic [COL_W-1:0] sh_act_w;
  logic [ROW_W-1:0] sh_f0_first, sh_f0_cnt, sh_f1_first, sh_f1_cnt;
  logic [FB_W-1:0]  sh_fb_cnt;
  logic [VB_W-1:0]  sh_vb_cnt;
  logic             sh_two_field, sh_one_field, sh_step2, sh_start_odd;
  logic [1:0]       sh_fmt;
  logic             col_active, row_last, in_image, frame_start;
  logic [ROW_W-1:0] row_addr;

  rdt_cfg_shadow #(
    .ROW_W(ROW_W), .COL_W(COL_W), .HB_W(HB_W), .FB_W(FB_W), .VB_W(VB_W), .LEN_W(LEN_W)
  ) u_shadow (
    .clk          (clk),
    .rst          (rst),
    .load         (frame_start),
    .in_row_start (cfg_row_start),
    .in_height    (cfg_height),
    .in_width     (cfg_width),
    .in_hblank    (cfg_hblank),
    .in_fblank    (cfg_fblank),
    .in_vb_a      (cfg_vblank_a),
    .in_vb_b      (cfg_vblank_b),
    .in_ctx_b     (cfg_ctx_b),
    .in_mode      (cfg_mode),
    .in_lv_fmt    (cfg_lv_fmt),
    .row_len_m1   (sh_row_len_m1),
    .act_w        (sh_act_w),
    .f0_first     (sh_f0_first),
    .f0_cnt       (sh_f0_cnt),
    .f1_first     (sh_f1_first),
    .f1_cnt       (sh_f1_cnt),
    .fb_cnt       (sh_fb_cnt),
    .vb_cnt       (sh_vb_cnt),
    .two_field    (sh_two_field),
    .one_field    (sh_one_field),
    .step2        (sh_step2),
    .start_odd    (sh_start_odd),
    .lv_fmt       (sh_fmt)
  );

  rdt_col_timer #(.COL_W(COL_W), .LEN_W(LEN_W)) u_col (
    .clk        (clk),
    .rst        (rst),
    .row_len_m1 (sh_row_len_m1),
    .act_w      (sh_act_w),
    .col_active (col_active),
    .row_last   (row_last)
  );

  rdt_row_seq #(.ROW_W(ROW_W), .FB_W(FB_W), .VB_W(VB_W)) u_rows (
    .clk         (clk),
    .rst         (rst),
    .row_last    (row_last),
    .f0_first    (sh_f0_first),
    .f0_cnt      (sh_f0_cnt),
    .f1_first    (sh_f1_first),
    .f1_cnt      (sh_f1_cnt),
    .fb_cnt      (sh_fb_cnt),
    .vb_cnt      (sh_vb_cnt),
    .two_field   (sh_two_field),
    .step2       (sh_step2),
    .in_image    (in_image),
    .row_addr    (row_addr),
    .frame_start (frame_start)
  );

  rdt_out_stage #(.ROW_W(ROW_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_image    (in_image),
    .col_active  (col_active),
    .row_addr    (row_addr),
    .lv_fmt      (sh_fmt),
    .row_idx     (row_idx),
    .col_strobe  (col_strobe),
    .frame_valid (frame_valid),
    .line_valid  (line_valid)
  );

endmodule

// File: rtl/rdt_readout_gen_chk.sv
module rdt_readout_gen_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [ROW_W-1:0] row_idx,
  input logic             col_strobe,
  input logic             frame_valid,
  input logic             line_valid,
  input logic [1:0]       sh_fmt,
  input logic             sh_one_field,
  input logic             sh_start_odd
);

  // R2: pixel strobe only inside image rows
  a_r2_strobe_in_image: assert property (@(posedge clk) disable iff (rst)
    col_strobe |-> frame_valid);

  // R8: row index parks at zero outside image rows
  a_r8_row_zero_blank: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> (row_idx == '0));

  // R9: gated shapes follow the pixel strobe
  a_r9_gated_lv: assert property (@(posedge clk) disable iff (rst)
    (($past(sh_fmt) == 2'd0) || ($past(sh_fmt) == 2'd3)) |-> (line_valid == col_strobe));

  // R9: XOR shape is the inverse of the strobe within image rows
  a_r9_xor_lv: assert property (@(posedge clk) disable iff (rst)
    (($past(sh_fmt) == 2'd2) && frame_valid) |-> (line_valid != col_strobe));

  // R5: single-field rows share the parity of the captured start row
  a_r5_field_parity: assert property (@(posedge clk) disable iff (rst)
    ($past(sh_one_field) && frame_valid) |-> (row_idx[0] == $past(sh_start_odd)));

endmodule

bind rdt_readout_gen rdt_readout_gen_chk #(.ROW_W(ROW_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .row_idx      (row_idx),
  .col_strobe   (col_strobe),
  .frame_valid  (frame_valid),
  .line_valid   (line_valid),
  .sh_fmt       (sh_fmt),
  .sh_one_field (sh_one_field),
  .sh_start_odd (sh_start_odd)
);

// File: tb/rdt_readout_gen_test.sv
`timescale 1ns/1ps
module rdt_readout_gen_test;

  typedef struct packed {
    logic [9:0] s;
    logic [9:0] h;
    logic [9:0] w;
    logic [9:0] hb;
    logic [7:0] fb;
    logic [8:0] vba;
    logic [8:0] vbb;
    logic       ctx;
    logic [2:0] mode;
    logic [1:0] fmt;
  } cfg_t;

  typedef struct packed {
    logic       fv;
    logic       lv;
    logic       cs;
    logic [9:0] row;
    logic       sof;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] cfg_row_start = '0, cfg_height = '0, cfg_width = '0, cfg_hblank = '0;
  logic [7:0] cfg_fblank = '0;
  logic [8:0] cfg_vblank_a = '0, cfg_vblank_b = '0;
  logic       cfg_ctx_b = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [1:0] cfg_lv_fmt = '0;
  logic [9:0] row_idx;
  logic       col_strobe, frame_valid, line_valid;

  int    n_vec = 0;
  int    n_bad = 0;
  int    sof_count = 0;
  bit    mon_en = 1'b0;
  item_t expq[$];
  cfg_t  plan[9];

  always #4 clk = ~clk;

  rdt_readout_gen uut (
    .clk(clk), .rst(rst),
    .cfg_row_start(cfg_row_start), .cfg_height(cfg_height), .cfg_width(cfg_width),
    .cfg_hblank(cfg_hblank), .cfg_fblank(cfg_fblank),
    .cfg_vblank_a(cfg_vblank_a), .cfg_vblank_b(cfg_vblank_b), .cfg_ctx_b(cfg_ctx_b),
    .cfg_mode(cfg_mode), .cfg_lv_fmt(cfg_lv_fmt),
    .row_idx(row_idx), .col_strobe(col_strobe),
    .frame_valid(frame_valid), .line_valid(line_valid)
  );

  task automatic apply(input cfg_t c);
    cfg_row_start = c.s;   cfg_height = c.h;  cfg_width = c.w;  cfg_hblank = c.hb;
    cfg_fblank = c.fb;     cfg_vblank_a = c.vba; cfg_vblank_b = c.vbb;
    cfg_ctx_b = c.ctx;     cfg_mode = c.mode; cfg_lv_fmt = c.fmt;
  endtask

  // R2 R8 R9: expected cycles of one row
  task automatic push_row(input cfg_t c, input bit img, input int addr, input bit sof);
    int we;
    we = (c.w == 0) ? 1 : int'(c.w);
    for (int k = 0; k < we + int'(c.hb); k++) begin
      item_t it;
      bit act;
      act = (k < we);
      it.fv  = img;
      it.cs  = img && act;
      it.row = img ? 10'(addr) : 10'd0;
      it.sof = sof && (k == 0);
      case (c.fmt)
        2'd1:    it.lv = act;
        2'd2:    it.lv = act ^ img;
        default: it.lv = img && act;
      endcase
      expq.push_back(it);
    end
  endtask

  // R6 R7: trailing blanking length
  function automatic int vb_rows(input cfg_t c);
    int v, f, t;
    v = c.ctx ? int'(c.vbb) : int'(c.vba);
    f = int'(c.fb);
    if (c.mode == 3'd1) begin
      t = v - f;
      if (t < 4 - f) t = 4 - f;
      if (t < 1) t = 1;
      return t;
    end
    return (v < 4) ? 4 : v;
  endfunction

  task automatic push_vb(input cfg_t c);
    for (int r = 0; r < vb_rows(c); r++) push_row(c, 1'b0, 0, 1'b0);
  endtask

  // R3 R4 R5 R11: image rows then trailing blanking
  task automatic push_frame(input cfg_t c);
    int h, s, e0, ne, o0, no;
    h = (c.h < 2) ? 2 : int'(c.h);
    s = int'(c.s);
    if (c.mode == 3'd1) begin
      e0 = s + (s % 2);
      ne = (s % 2 == 1) ? h / 2 : h - h / 2;
      o0 = (s % 2 == 1) ? s : s + 1;
      no = h - ne;
      for (int i = 0; i < ne; i++) push_row(c, 1'b1, e0 + 2 * i, i == 0);
      for (int i = 0; i < int'(c.fb); i++) push_row(c, 1'b0, 0, 1'b0);
      for (int i = 0; i < no; i++) push_row(c, 1'b1, o0 + 2 * i, 1'b0);
    end else if (c.mode == 3'd2) begin
      for (int i = 0; i < h / 2; i++) push_row(c, 1'b1, s + 2 * i, i == 0);
    end else begin
      for (int i = 0; i < h; i++) push_row(c, 1'b1, s + i, i == 0);
    end
    push_vb(c);
  endtask

  task automatic check_reset_state();
    n_vec++;
    if (frame_valid !== 1'b0 || line_valid !== 1'b0 || col_strobe !== 1'b0 || row_idx !== 10'd0) begin
      n_bad++;
      $display("FAIL R1 reset state: fv=%b lv=%b cs=%b row=%0d expected all 0",
               frame_valid, line_valid, col_strobe, row_idx);
    end
  endtask

  // monitor: pop one expected item per clock and compare
  always @(negedge clk) begin
    if (mon_en) begin
      item_t e;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R10 scoreboard underflow: actual output with no expected item, expected a queued item");
      end else begin
        e = expq.pop_front();
        n_vec++;
        if (e.sof) sof_count++;
        if (frame_valid !== e.fv || line_valid !== e.lv || col_strobe !== e.cs || row_idx !== e.row) begin
          n_bad++;
          if (frame_valid !== e.fv)
            $display("FAIL R8 frame_valid actual %b expected %b", frame_valid, e.fv);
          if (line_valid !== e.lv)
            $display("FAIL R9 line_valid actual %b expected %b", line_valid, e.lv);
          if (col_strobe !== e.cs)
            $display("FAIL R2 col_strobe actual %b expected %b", col_strobe, e.cs);
          if (row_idx !== e.row)
            $display("FAIL R3 R4 R5 R11 row_idx actual %0d expected %0d", row_idx, e.row);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    //          s     h     w     hb    fb   vba   vbb  ctx mode fmt
    plan[0] = '{10'd3, 10'd5, 10'd6, 10'd3, 8'd0, 9'd2, 9'd7, 1'b0, 3'd0, 2'd0}; // R3 R6 clamp to 4
    plan[1] = '{10'd2, 10'd6, 10'd5, 10'd2, 8'd3, 9'd9, 9'd1, 1'b0, 3'd1, 2'd1}; // R4 R6 trailing 6
    plan[2] = '{10'd5, 10'd7, 10'd4, 10'd3, 8'd2, 9'd1, 9'd3, 1'b1, 3'd1, 2'd2}; // R4 R7 odd start, trailing 2
    plan[3] = '{10'd7, 10'd6, 10'd5, 10'd2, 8'd9, 9'd5, 9'd2, 1'b0, 3'd2, 2'd0}; // R5 odd field
    plan[4] = '{10'd4, 10'd5, 10'd3, 10'd4, 8'd0, 9'd2, 9'd6, 1'b1, 3'd2, 2'd3}; // R5 R7 even field
    plan[5] = '{10'd1, 10'd4, 10'd4, 10'd2, 8'd0, 9'd2, 9'd6, 1'b1, 3'd1, 2'd2}; // R11 no field gap
    plan[6] = '{10'd6, 10'd4, 10'd3, 10'd2, 8'd6, 9'd3, 9'd9, 1'b0, 3'd1, 2'd1}; // R6 trailing floor 1
    plan[7] = '{10'd9, 10'd1, 10'd0, 10'd0, 8'd0, 9'd6, 9'd2, 1'b0, 3'd5, 2'd2}; // R2 R3 clamps
    plan[8] = '{10'd0, 10'd3, 10'd4, 10'd1, 8'd5, 9'd1, 9'd5, 1'b1, 3'd0, 2'd1}; // R7 context B

    apply(plan[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state(); // R1
    push_vb(plan[0]);
    push_frame(plan[0]);
    rst = 1'b0;
    @(posedge clk);
    mon_en = 1'b1;

    // R10: every rewrite lands mid-frame, takes effect one frame later
    for (int i = 1; i < 9; i++) begin
      wait (sof_count == i);
      apply(plan[i]);
      push_frame(plan[i]);
    end
    wait (sof_count == 9);
    wait (expq.size() == 0);
    mon_en = 1'b0;

    // R1: reset in mid-frame returns to vertical blanking
    @(negedge clk);
    apply(plan[3]);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    push_vb(plan[3]);
    push_frame(plan[3]);
    rst = 1'b0;
    @(posedge clk);
    mon_en = 1'b1;
    wait (sof_count == 10);
    wait (expq.size() == 0);
    mon_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule